// File: doc/BRIEF.md
# IrDA/LIN-capable asynchronous serial transceiver

This block is a UART with one transmit shift path and one receive shift path, each holding a single character. A 13-bit divisor sets the rate of an oversampling tick, and sixteen of these ticks make one bit time. Characters are 8 or 9 data bits, least significant bit first. The character sits between a low start bit and a high stop bit.

The line can carry plain NRZ levels. It can also carry a return-to-zero-inverted infrared coding, in which only zero bits produce a short pulse. The pulse width is programmable. The transmit and receive line levels can each be inverted.

For LIN-style buses the transmitter can send a break. The receiver flags a long dominant period as a break. The transmitter compares the level it reads back with the bit it is driving and reports a collision. A single-wire option feeds the receiver from the wired-AND of the receive pin and the transmit pin. A wake flag reports the first active (falling) edge on the conditioned receive line.

Top module: `uart_irlin`

## Requirements
- R1: One tick occurs every `div` clock cycles, and every transmitted bit lasts exactly 16 ticks (16*div clocks). When `div` is 0 no tick occurs, and a requested character is held back without any change on `txd`.
- R2: An NRZ character is a 0 start bit, then the data bits LSB first (9 bits when `len9`=1, else 8), then a 1 stop bit. The idle line is 1. A received 8-bit character appears on `rx_data` with bit 8 forced to 0.
- R3: `tx_inv`=1 inverts every level driven on `txd`. `rx_inv`=1 inverts the level taken from the receive input before decoding.
- R4: With `rzi_en`=1, a zero bit drives a 1 pulse (before inversion) at the start of the bit. The pulse lasts 3*div clocks for `rzi_pw`=0, div clocks for 1, and max(div/2,1) clocks for 2 or 3. A one bit and the idle line drive 0.
- R5: With `rzi_en`=1, the receiver treats each received pulse as a zero bit and the absence of a pulse as a one bit. It recovers the characters sent by R4.
- R6: The receiver takes three samples at ticks 7, 8 and 9 of each bit and keeps the majority value. A start bit whose majority is 1 is dropped and produces no character. A stop bit whose majority is 0 still delivers the character, with `rx_ferr`=1. `rx_valid` is a one-cycle pulse.
- R7: A request with `tx_brk`=1 sends 13 zero bit times and then a 1 stop bit. The line is therefore low for 208 ticks.
- R8: The receive line staying low for 11 bit times (176 ticks) raises `rx_brk` for exactly one cycle per low period. An all-zero character (at most 10 low bits) never raises it.
- R9: In NRZ mode, at tick 8 of each transmitted bit, a decoded receive level that differs from the driven bit raises `tx_col` for one cycle. `tx_col` never rises while idle or in RZI mode.
- R10: With `single_wire`=1, the receiver input is `rxd & txd`. The transmitter therefore reads back its own characters, and any external low pulls the bus down.
- R11: With `wake_en`=1, a 1-to-0 transition of the decoded receive line raises `wake` for one cycle. With `wake_en`=0, `wake` stays 0.
- R12: `tx_start` is ignored while `tx_busy`=1. The pending or current character is neither replaced nor repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| div | input | 13 | Clocks per oversampling tick; 0 stops the tick |
| len9 | input | 1 | 1 = 9 data bits, 0 = 8 data bits |
| tx_inv | input | 1 | Invert transmit line |
| rx_inv | input | 1 | Invert receive line |
| rzi_en | input | 1 | Select return-to-zero-inverted coding |
| rzi_pw | input | 2 | RZI pulse width: 0 = 3/16, 1 = 1/16, 2/3 = 1/32 bit |
| single_wire | input | 1 | Receiver reads the wired-AND of rxd and txd |
| wake_en | input | 1 | Enable wake flag on active edge |
| tx_start | input | 1 | Request to send one character or a break |
| tx_brk | input | 1 | With tx_start: send a break instead of data |
| tx_data | input | 9 | Character to send |
| tx_busy | output | 1 | A request is pending or being sent |
| txd | output | 1 | Transmit line |
| rxd | input | 1 | Receive line |
| rx_valid | output | 1 | One-cycle pulse: character received |
| rx_data | output | 9 | Received character |
| rx_ferr | output | 1 | Stop bit of the delivered character was 0 |
| rx_brk | output | 1 | One-cycle pulse: break detected |
| tx_col | output | 1 | One-cycle pulse: transmit collision |
| wake | output | 1 | One-cycle pulse: active edge seen |

## Verification
The embedded properties check the following on every cycle:
- ticks never occur with a zero divisor;
- the NRZ idle level follows the transmit polarity;
- a request made while busy leaves the latched character untouched;
- collisions appear only during NRZ transmission;
- the receive, break and wake flags are single-cycle pulses gated as required.

Some behaviour can only be shown by the bench scenarios:
- exact bit and pulse durations, and the break length on the line;
- that characters survive the round trip under each coding, width and polarity;
- rejection of a short false start, and the framing error;
- break detection versus an all-zero character;
- collision detection on a shared single wire.

// File: rtl/uart_irlin_pkg.sv
package uart_irlin_pkg;
  localparam int OSR     = 16;
  localparam int BRK_BIT = 11;
  localparam int RZI_HOLD = 13;

  function automatic logic maj3(input logic [2:0] s);
    return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
  endfunction
endpackage

// File: rtl/uart_baud.sv
module uart_baud #(
  parameter int DIV_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (div == '0) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= div - 1'b1) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

  // R1
  tick_needs_div_chk: assert property (@(posedge clk) disable iff (rst)
    tick |-> ($past(div) != '0));
endmodule

// File: rtl/uart_tx.sv
module uart_tx #(
  parameter int DIV_W  = 13,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [DIV_W-1:0]  div,
  input  logic              len9,
  input  logic              inv,
  input  logic              rzi,
  input  logic [1:0]        pw,
  input  logic              start,
  input  logic              brk,
  input  logic [DATA_W-1:0] data,
  input  logic              rdbk,
  output logic              busy,
  output logic              txd,
  output logic              col
);
  localparam int SH_W = 16;
  localparam int PW_W = DIV_W + 2;

  logic              req, req_brk, active;
  logic [DATA_W-1:0] req_data;
  logic [SH_W-1:0]   sh;
  logic [3:0]        tcnt, bcnt, nbits;
  logic [PW_W-1:0]   pwc, w_clk, dz;
  logic              nrz, pulse, line_nxt;

  assign busy = req | active;
  assign dz   = {2'b00, div};

  always_comb begin
    case (pw)
      2'd0:    w_clk = dz + dz + dz;
      2'd1:    w_clk = dz;
      default: w_clk = ((dz >> 1) == '0) ? PW_W'(1) : (dz >> 1);
    endcase
  end

  assign nrz      = active ? sh[0] : 1'b1;
  assign pulse    = active && !sh[0] && (pwc != '0);
  assign line_nxt = (rzi ? pulse : nrz) ^ inv;

  always_ff @(posedge clk) begin
    if (rst) begin
      req <= 1'b0; req_brk <= 1'b0; req_data <= '0; active <= 1'b0;
      sh <= '1; tcnt <= '0; bcnt <= '0; nbits <= '0; pwc <= '0;
      txd <= 1'b1; col <= 1'b0;
    end else begin
      col <= 1'b0;
      if (start && !req && !active) begin
        req      <= 1'b1;
        req_brk  <= brk;
        req_data <= data;
      end
      if (pwc != '0) pwc <= pwc - 1'b1;
      if (tick) begin
        if (req && !active) begin
          active <= 1'b1;
          req    <= 1'b0;
          tcnt   <= '0;
          bcnt   <= '0;
          pwc    <= w_clk;
          if (req_brk) begin
            sh <= 16'h2000; nbits <= 4'd14;
          end else if (len9) begin
            sh <= {6'b0, 1'b1, req_data[8:0], 1'b0}; nbits <= 4'd11;
          end else begin
            sh <= {7'b0, 1'b1, req_data[7:0], 1'b0}; nbits <= 4'd10;
          end
        end else if (active) begin
          if (tcnt == 4'd8 && !rzi && rdbk != sh[0]) col <= 1'b1;
          tcnt <= tcnt + 1'b1;
          if (tcnt == 4'd15) begin
            sh  <= {1'b1, sh[SH_W-1:1]};
            pwc <= w_clk;
            if (bcnt == nbits - 4'd1) active <= 1'b0;
            else bcnt <= bcnt + 1'b1;
          end
        end
      end
      txd <= line_nxt;
    end
  end

  // R2
  nrz_idle_level_chk: assert property (@(posedge clk) disable iff (rst)
    (!active && !rzi) |=> (txd == !$past(inv)));
  // R12
  busy_req_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (start && busy) |=> $stable(req_data));
  // R9
  col_only_nrz_tx_chk: assert property (@(posedge clk) disable iff (rst)
    col |-> ($past(active) && !$past(rzi)));
endmodule

// File: rtl/uart_rx.sv
module uart_rx
  import uart_irlin_pkg::*;
#(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              raw,
  input  logic              inv,
  input  logic              rzi,
  input  logic              len9,
  input  logic              wake_en,
  output logic              line,
  output logic              valid,
  output logic [DATA_W-1:0] data,
  output logic              ferr,
  output logic              brk,
  output logic              wake
);
  localparam int BRK_T = BRK_BIT * OSR;
  localparam int LC_W  = $clog2(BRK_T + 1);

  logic              s1, s2, lvl, line_q, busy, m;
  logic [3:0]        hcnt, tcnt, bidx, nd;
  logic [2:0]        smp;
  logic [DATA_W-1:0] sh;
  logic [LC_W-1:0]   lowcnt;

  assign lvl  = s2 ^ inv;
  assign line = rzi ? !(lvl || hcnt != '0) : lvl;
  assign nd   = len9 ? 4'd9 : 4'd8;
  assign m    = maj3(smp);

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b1; s2 <= 1'b1; hcnt <= '0; line_q <= 1'b1; wake <= 1'b0;
      busy <= 1'b0; tcnt <= '0; bidx <= '0; smp <= '0; sh <= '0;
      valid <= 1'b0; data <= '0; ferr <= 1'b0; brk <= 1'b0; lowcnt <= '0;
    end else begin
      s1     <= raw;
      s2     <= s1;
      line_q <= line;
      wake   <= wake_en && line_q && !line;
      valid  <= 1'b0;
      brk    <= tick && !line && (lowcnt == LC_W'(BRK_T - 1));
      if (rzi && lvl) hcnt <= 4'(RZI_HOLD);
      else if (tick && hcnt != '0) hcnt <= hcnt - 1'b1;
      if (line) lowcnt <= '0;
      else if (tick && lowcnt != LC_W'(BRK_T)) lowcnt <= lowcnt + 1'b1;
      if (tick) begin
        if (!busy) begin
          if (!line) begin
            busy <= 1'b1; tcnt <= '0; bidx <= '0;
          end
        end else begin
          tcnt <= tcnt + 1'b1;
          if (tcnt == 4'd7 || tcnt == 4'd8 || tcnt == 4'd9) smp <= {smp[1:0], line};
          if (tcnt == 4'd15) begin
            bidx <= bidx + 1'b1;
            if (bidx == '0) begin
              if (m) busy <= 1'b0;
            end else if (bidx <= nd) begin
              sh <= {m, sh[DATA_W-1:1]};
            end else begin
              busy  <= 1'b0;
              valid <= 1'b1;
              ferr  <= !m;
              data  <= len9 ? sh : {1'b0, sh[DATA_W-1:1]};
            end
          end
        end
      end
    end
  end

  // R6
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);
  // R8
  brk_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    brk |=> !brk);
  // R11
  wake_gated_chk: assert property (@(posedge clk) disable iff (rst)
    wake |-> $past(wake_en));
endmodule

// File: rtl/uart_irlin.sv
module uart_irlin #(
  parameter int DIV_W  = 13,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  div,
  input  logic              len9,
  input  logic              tx_inv,
  input  logic              rx_inv,
  input  logic              rzi_en,
  input  logic [1:0]        rzi_pw,
  input  logic              single_wire,
  input  logic              wake_en,
  input  logic              tx_start,
  input  logic              tx_brk,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_busy,
  output logic              txd,
  input  logic              rxd,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_ferr,
  output logic              rx_brk,
  output logic              tx_col,
  output logic              wake
);
  logic tick, rx_line, rx_raw;

  assign rx_raw = single_wire ? (rxd & txd) : rxd;

  uart_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst(rst), .div(div), .tick(tick)
  );

  uart_tx #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst(rst), .tick(tick), .div(div), .len9(len9), .inv(tx_inv),
    .rzi(rzi_en), .pw(rzi_pw), .start(tx_start), .brk(tx_brk), .data(tx_data),
    .rdbk(rx_line), .busy(tx_busy), .txd(txd), .col(tx_col)
  );

  uart_rx #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst(rst), .tick(tick), .raw(rx_raw), .inv(rx_inv), .rzi(rzi_en),
    .len9(len9), .wake_en(wake_en), .line(rx_line), .valid(rx_valid),
    .data(rx_data), .ferr(rx_ferr), .brk(rx_brk), .wake(wake)
  );
endmodule

// File: tb/sim_uart_irlin.sv
module sim_uart_irlin;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst = 1'b1;
  logic [12:0] div = 13'd4;
  logic        len9 = 0, tx_inv = 0, rx_inv = 0, rzi_en = 0, single_wire = 0, wake_en = 0;
  logic [1:0]  rzi_pw = 0;
  logic        tx_start = 0, tx_brk = 0;
  logic [8:0]  tx_data = 0;
  logic        tx_busy, txd, rx_valid, rx_ferr, rx_brk, tx_col, wake;
  logic [8:0]  rx_data;
  logic        loop = 1'b1, ext_rxd = 1'b1;
  wire         rxd = loop ? txd : ext_rxd;

  uart_irlin u0 (
    .clk(clk), .rst(rst), .div(div), .len9(len9), .tx_inv(tx_inv), .rx_inv(rx_inv),
    .rzi_en(rzi_en), .rzi_pw(rzi_pw), .single_wire(single_wire), .wake_en(wake_en),
    .tx_start(tx_start), .tx_brk(tx_brk), .tx_data(tx_data), .tx_busy(tx_busy),
    .txd(txd), .rxd(rxd), .rx_valid(rx_valid), .rx_data(rx_data), .rx_ferr(rx_ferr),
    .rx_brk(rx_brk), .tx_col(tx_col), .wake(wake)
  );

  int n_chk = 0, n_fail = 0;
  int n_valid = 0, n_brk = 0, n_col = 0, n_wake = 0;
  logic [8:0] last_data = 0;
  logic       last_ferr = 0;

  always @(negedge clk) if (!rst) begin
    if (rx_valid) begin n_valid++; last_data = rx_data; last_ferr = rx_ferr; end
    if (rx_brk) n_brk++;
    if (tx_col) n_col++;
    if (wake) n_wake++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [8:0] d, input logic b);
    @(negedge clk);
    tx_start = 1'b1; tx_brk = b; tx_data = d;
    @(negedge clk);
    tx_start = 1'b0; tx_brk = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_valid(input int base);
    for (int i = 0; i < 3000 && n_valid == base; i++) @(negedge clk);
  endtask

  task automatic wait_done();
    for (int i = 0; i < 3000 && tx_busy; i++) @(negedge clk);
    idle(200);
  endtask

  // length of the first run of txd at level lv
  task automatic run_len(input logic lv, output int n);
    n = 0;
    for (int i = 0; i < 3000 && txd != lv; i++) @(negedge clk);
    for (int i = 0; i < 3000 && txd == lv; i++) begin n++; @(negedge clk); end
  endtask

  // {len9, inv, rzi, pw[1:0], data[8:0]}
  localparam logic [13:0] VEC [8] = '{
    {1'b0, 1'b0, 1'b0, 2'd0, 9'h0A5},
    {1'b0, 1'b0, 1'b0, 2'd0, 9'h000},
    {1'b1, 1'b0, 1'b0, 2'd0, 9'h1C3},
    {1'b0, 1'b1, 1'b0, 2'd0, 9'h05A},
    {1'b1, 1'b1, 1'b0, 2'd0, 9'h10F},
    {1'b0, 1'b0, 1'b1, 2'd0, 9'h096},
    {1'b0, 1'b0, 1'b1, 2'd1, 9'h133},
    {1'b1, 1'b1, 1'b1, 2'd2, 9'h1E1}
  };

  initial begin
    repeat (170000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int base, n;
    logic [8:0] exp;
    idle(4);
    rst = 1'b0;
    @(negedge clk);
    // R2 reset/idle state
    chk(txd == 1'b1 && !tx_busy && !rx_valid, "R2 reset idle", {txd, tx_busy, rx_valid}, 3'b100);
    idle(100);

    // vector table: loopback round trips (R2 R3 R4 R5)
    for (int v = 0; v < 8; v++) begin
      len9 = VEC[v][13]; tx_inv = VEC[v][12]; rx_inv = VEC[v][12];
      rzi_en = VEC[v][11]; rzi_pw = VEC[v][10:9];
      exp = VEC[v][13] ? VEC[v][8:0] : {1'b0, VEC[v][7:0]};
      idle(1600);
      base = n_valid;
      send(VEC[v][8:0], 1'b0);
      wait_valid(base);
      chk(n_valid > base && last_data == exp, "R2 R3 R5 round trip data", last_data, exp);
      chk(last_ferr == 1'b0, "R6 no framing error", last_ferr, 0);
      wait_done();
      chk(n_valid == base + 1, "R2 one character per request", n_valid - base, 1);
    end
    // R8 all-zero character gave no break, R9 clean loopback gave no collision
    chk(n_brk == 0, "R8 zero char no break", n_brk, 0);
    chk(n_col == 0, "R9 no collision on loopback", n_col, 0);

    // R4 pulse widths, div=4
    len9 = 0; tx_inv = 0; rx_inv = 0; rzi_en = 1;
    for (int p = 0; p < 3; p++) begin
      rzi_pw = 2'(p);
      idle(1600);
      send(9'h000, 1'b0);
      run_len(1'b1, n);
      chk(n == (p == 0 ? 12 : p == 1 ? 4 : 2), "R4 rzi pulse width", n, p == 0 ? 12 : p == 1 ? 4 : 2);
      wait_done();
    end
    rzi_en = 0; rzi_pw = 0;
    idle(1600);

    // R1 bit duration at two divisors
    for (int k = 0; k < 2; k++) begin
      div = k ? 13'd6 : 13'd4;
      idle(200);
      send(9'h001, 1'b0);
      run_len(1'b0, n);
      chk(n == 16 * int'(div), "R1 start bit length", n, 16 * int'(div));
      wait_done();
    end
    div = 13'd4;
    idle(400);

    // R1 divisor zero holds the request
    div = 13'd0;
    idle(10);
    send(9'h0F0, 1'b0);
    n = 0;
    for (int i = 0; i < 500; i++) begin
      if (txd != 1'b1) n++;
      @(negedge clk);
    end
    chk(n == 0 && tx_busy, "R1 no bit without tick", n, 0);
    base = n_valid;
    div = 13'd4;
    wait_valid(base);
    chk(last_data == 9'h0F0, "R1 resumes after divisor", last_data, 9'h0F0);
    wait_done();

    // R12 start while busy ignored
    base = n_valid;
    send(9'h011, 1'b0);
    idle(100);
    send(9'h022, 1'b0);
    wait_valid(base);
    wait_done();
    idle(1000);
    chk(n_valid == base + 1 && last_data == 9'h011, "R12 busy start ignored", last_data, 9'h011);

    // R7 R8 break
    base = n_brk;
    send(9'h000, 1'b1);
    run_len(1'b0, n);
    chk(n == 13 * 64, "R7 break low time", n, 13 * 64);
    wait_done();
    idle(1500);
    chk(n_brk == base + 1, "R8 one break flag", n_brk - base, 1);

    // R6 false start and framing error, driven externally
    loop = 0; ext_rxd = 1;
    idle(200);
    base = n_valid;
    ext_rxd = 0; idle(8); ext_rxd = 1;
    idle(1200);
    chk(n_valid == base, "R6 short low rejected", n_valid - base, 0);
    begin
      logic [9:0] fr;
      fr = {1'b0, 8'h55, 1'b0};
      for (int b = 0; b < 10; b++) begin ext_rxd = fr[b]; idle(64); end
      ext_rxd = 1;
    end
    wait_valid(base);
    chk(last_data == 9'h055 && last_ferr, "R6 framing error", {last_ferr, last_data}, 10'h255);
    idle(1500);

    // R10 single wire own readback, R9 collision
    single_wire = 1;
    idle(200);
    base = n_valid; n = n_col;
    send(9'h03C, 1'b0);
    wait_valid(base);
    wait_done();
    chk(last_data == 9'h03C && n_col == n, "R10 single wire readback", last_data, 9'h03C);
    ext_rxd = 0;
    idle(400);
    n = n_col;
    send(9'h0FF, 1'b0);
    wait_done();
    chk(n_col > n, "R9 collision on pulled bus", n_col - n, 1);
    ext_rxd = 1;
    single_wire = 0;
    idle(2000);

    // R11 wake
    wake_en = 0; base = n_wake;
    ext_rxd = 0; idle(20); ext_rxd = 1; idle(1500);
    chk(n_wake == base, "R11 no wake when disabled", n_wake - base, 0);
    wake_en = 1;
    ext_rxd = 0; idle(20);
    chk(n_wake == base + 1, "R11 wake on falling edge", n_wake - base, 1);
    ext_rxd = 1; idle(1500);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule